// File: doc/BRIEF.md
# Sample Statistics Monitor

The block sits beside a 22-bit signed sample bus and watches it without changing it. It runs one of four functions at a time. Two of them track an extreme: the largest value seen, or the smallest. The other two count how many samples land above, or below, a fixed threshold. One 24-bit level register holds either the running extreme or the fixed threshold. A saturating counter records either the number of extreme updates or the number of threshold crossings.

The bus marks a sample that left its range with one of two overflow flags, one for each direction. The monitor takes such a flag as the true direction of the sample. The 22-bit value carried with a flagged sample is not used.

Software reads the level and the count through two buffered copies. A snapshot strobe fills both copies at the same edge, so the pair always belongs together. A clear input zeroes the live counter. A load input writes the level register directly, which is how a threshold is set or tracking is seeded.

Top module: `sample_stats_mon`

## Requirements
- R1: While rst_ni is low, the level, the count and both buffers read zero.
- R2: A cycle with valid_i low changes neither the level nor the count.
- R3: With track_i=0 and dir_max_i=1 (overshoot counting), a valid sample whose two's-complement value is strictly greater than level_o[21:0] adds one to the count. A sample equal to that value, or below it, has no effect.
- R4: With track_i=0 and dir_max_i=0 (undershoot counting), a valid sample strictly less than level_o[21:0] adds one to the count. A sample that is equal or greater has no effect.
- R5: In the counting functions a valid sample with pos_ovf_i high counts as above the threshold, and one with neg_ovf_i high counts as below it, whatever its data bits are. If both flags are high, pos_ovf_i wins.
- R6: With track_i=1 and dir_max_i=1 (maximum tracking), a valid unflagged sample greater than level_o[21:0] is stored, sign-extended to 24 bits, and the count goes up by one.
- R7: With track_i=1 and dir_max_i=0 (minimum tracking), a valid unflagged sample less than level_o[21:0] is stored, sign-extended, and the count goes up by one.
- R8: In the tracking functions a sample with either overflow flag set never changes the level and never adds to the count.
- R9: The count is unsigned. It stops at all ones (3FFFFF hex at the default width) and never wraps.
- R10: snap_i copies the level and the count as they were before the edge into level_buf_o and count_buf_o. Without snap_i the buffers hold their values.
- R11: clr_i zeroes the count at the next edge. This takes precedence over any increment in the same cycle.
- R12: thr_load_i writes thr_data_i into the level register, taking precedence over a sample update in the same cycle. In the counting functions no sample ever changes the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | SAMPLE_W (22) | Signed sample on the bus |
| valid_i | input | 1 | The sample is present this cycle |
| pos_ovf_i | input | 1 | The sample overflowed in the positive direction |
| neg_ovf_i | input | 1 | The sample overflowed in the negative direction |
| dir_max_i | input | 1 | 1: max/overshoot, 0: min/undershoot |
| track_i | input | 1 | 1: tracking functions, 0: counting functions |
| thr_load_i | input | 1 | Write thr_data_i into the level register |
| thr_data_i | input | REG_W (24) | Value to load |
| snap_i | input | 1 | Copy the level and the count into the buffers |
| clr_i | input | 1 | Zero the counter |
| level_o | output | REG_W (24) | Live level register |
| count_o | output | CNT_W (22) | Live counter |
| level_buf_o | output | REG_W (24) | Buffered level |
| count_buf_o | output | CNT_W (22) | Buffered count |

## Verification
The bench builds the block with SAMPLE_W=22 and REG_W=24, as in the defaults, and narrows CNT_W to 6. The narrow counter reaches saturation after 63 increments, so a short run can drive it into the stop value and then push past it. The full sample width is kept, so samples at the most negative code, samples equal to the threshold and sign extension into bits 23:22 are all exercised at their real size.

// File: rtl/sample_stats_pkg.sv
package sample_stats_pkg;
  // {track, dir_max}
  typedef enum logic [1:0] {
    FN_UNDER = 2'b00,
    FN_OVER  = 2'b01,
    FN_MIN   = 2'b10,
    FN_MAX   = 2'b11
  } stat_fn_e;
endpackage

// File: rtl/stats_judge.sv
module stats_judge
  import sample_stats_pkg::*;
#(
  parameter int SAMPLE_W = 22
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thr_i,
  input  logic                pos_ovf_i,
  input  logic                neg_ovf_i,
  input  stat_fn_e            fn_i,
  output logic                count_hit_o,
  output logic                store_o
);
  logic above, below, flagged;

  always_comb begin
    flagged = pos_ovf_i | neg_ovf_i;
    if (pos_ovf_i) begin
      above = 1'b1;
      below = 1'b0;
    end else if (neg_ovf_i) begin
      above = 1'b0;
      below = 1'b1;
    end else begin
      above = $signed(sample_i) > $signed(thr_i);
      below = $signed(sample_i) < $signed(thr_i);
    end
  end

  always_comb begin
    count_hit_o = 1'b0;
    store_o     = 1'b0;
    unique case (fn_i)
      FN_OVER:  count_hit_o = above;
      FN_UNDER: count_hit_o = below;
      FN_MAX: begin
        store_o     = above & ~flagged;
        count_hit_o = above & ~flagged;
      end
      FN_MIN: begin
        store_o     = below & ~flagged;
        count_hit_o = below & ~flagged;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stats_sat_cnt.sv
module stats_sat_cnt #(
  parameter int CNT_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             at_top;

  assign at_top = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (inc_i && !at_top) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stats_level_reg.sv
module stats_level_reg #(
  parameter int SAMPLE_W = 22,
  parameter int REG_W    = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [REG_W-1:0]    load_val_i,
  input  logic                store_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [REG_W-1:0]    level_o
);
  localparam int EXT_W = REG_W - SAMPLE_W;

  logic [REG_W-1:0] ext_sample;
  logic [REG_W-1:0] level_q;

  generate
    if (EXT_W > 0) begin : g_ext
      assign ext_sample = {{EXT_W{sample_i[SAMPLE_W-1]}}, sample_i};
    end else begin : g_same
      assign ext_sample = sample_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      level_q <= '0;
    else if (load_i)  level_q <= load_val_i;
    else if (store_i) level_q <= ext_sample;
  end

  assign level_o = level_q;
endmodule

// File: rtl/stats_snap_buf.sv
module stats_snap_buf #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         snap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (snap_i) q_o <= d_i;
  end
endmodule

// File: rtl/sample_stats_mon.sv
module sample_stats_mon
  import sample_stats_pkg::*;
#(
  parameter int SAMPLE_W = 22,
  parameter int REG_W    = 24,
  parameter int CNT_W    = 22
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                valid_i,
  input  logic                pos_ovf_i,
  input  logic                neg_ovf_i,
  input  logic                dir_max_i,
  input  logic                track_i,
  input  logic                thr_load_i,
  input  logic [REG_W-1:0]    thr_data_i,
  input  logic                snap_i,
  input  logic                clr_i,
  output logic [REG_W-1:0]    level_o,
  output logic [CNT_W-1:0]    count_o,
  output logic [REG_W-1:0]    level_buf_o,
  output logic [CNT_W-1:0]    count_buf_o
);
  stat_fn_e         fn;
  logic             count_hit, store;
  logic [REG_W-1:0] level;
  logic [CNT_W-1:0] count;

  assign fn = stat_fn_e'({track_i, dir_max_i});

  stats_judge #(.SAMPLE_W(SAMPLE_W)) u_judge (
    .sample_i    (sample_i),
    .thr_i       (level[SAMPLE_W-1:0]),
    .pos_ovf_i   (pos_ovf_i),
    .neg_ovf_i   (neg_ovf_i),
    .fn_i        (fn),
    .count_hit_o (count_hit),
    .store_o     (store)
  );

  stats_level_reg #(.SAMPLE_W(SAMPLE_W), .REG_W(REG_W)) u_level (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (thr_load_i),
    .load_val_i (thr_data_i),
    .store_i    (valid_i & store),
    .sample_i   (sample_i),
    .level_o    (level)
  );

  stats_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .inc_i  (valid_i & count_hit),
    .cnt_o  (count)
  );

  stats_snap_buf #(.W(REG_W)) u_level_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .snap_i (snap_i),
    .d_i    (level),
    .q_o    (level_buf_o)
  );

  stats_snap_buf #(.W(CNT_W)) u_count_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .snap_i (snap_i),
    .d_i    (count),
    .q_o    (count_buf_o)
  );

  assign level_o = level;
  assign count_o = count;
endmodule

// File: rtl/sample_stats_mon_chk.sv
module sample_stats_mon_chk #(
  parameter int SAMPLE_W = 22,
  parameter int REG_W    = 24,
  parameter int CNT_W    = 22
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic                valid_i,
  input logic                pos_ovf_i,
  input logic                neg_ovf_i,
  input logic                dir_max_i,
  input logic                track_i,
  input logic                thr_load_i,
  input logic [REG_W-1:0]    thr_data_i,
  input logic                snap_i,
  input logic                clr_i,
  input logic [REG_W-1:0]    level_o,
  input logic [CNT_W-1:0]    count_o,
  input logic [REG_W-1:0]    level_buf_o,
  input logic [CNT_W-1:0]    count_buf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_comb begin
    if (!rst_ni) begin
      assert_reset_zero_R1: assert (level_o == '0 && count_o == '0 &&
                                    level_buf_o == '0 && count_buf_o == '0);
    end
  end

  assert_idle_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(count_o));

  assert_idle_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !thr_load_i) |=> $stable(level_o));

  assert_no_count_at_or_below_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !track_i && dir_max_i && !pos_ovf_i && !neg_ovf_i && !clr_i &&
     $signed(sample_i) <= $signed(level_o[SAMPLE_W-1:0])) |=> $stable(count_o));

  assert_no_count_at_or_above_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !track_i && !dir_max_i && !pos_ovf_i && !neg_ovf_i && !clr_i &&
     $signed(sample_i) >= $signed(level_o[SAMPLE_W-1:0])) |=> $stable(count_o));

  assert_new_max_stored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && track_i && dir_max_i && !pos_ovf_i && !neg_ovf_i && !thr_load_i &&
     $signed(sample_i) > $signed(level_o[SAMPLE_W-1:0]))
    |=> $signed(level_o) == $signed($past(sample_i)));

  assert_flagged_no_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && track_i && (pos_ovf_i || neg_ovf_i) && !thr_load_i) |=> $stable(level_o));

  assert_saturate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && count_o == CNT_MAX) |=> count_o == CNT_MAX);

  assert_snap_copy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (level_buf_o == $past(level_o) && count_buf_o == $past(count_o)));

  assert_buf_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> ($stable(level_buf_o) && $stable(count_buf_o)));

  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0);

  assert_load_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_load_i |=> level_o == $past(thr_data_i));

  assert_static_level_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!track_i && !thr_load_i) |=> $stable(level_o));
endmodule

bind sample_stats_mon sample_stats_mon_chk #(
  .SAMPLE_W(SAMPLE_W), .REG_W(REG_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_i    (sample_i),
  .valid_i     (valid_i),
  .pos_ovf_i   (pos_ovf_i),
  .neg_ovf_i   (neg_ovf_i),
  .dir_max_i   (dir_max_i),
  .track_i     (track_i),
  .thr_load_i  (thr_load_i),
  .thr_data_i  (thr_data_i),
  .snap_i      (snap_i),
  .clr_i       (clr_i),
  .level_o     (level_o),
  .count_o     (count_o),
  .level_buf_o (level_buf_o),
  .count_buf_o (count_buf_o)
);

// File: tb/sample_stats_mon_tb_top.sv
`timescale 1ns/1ps
module sample_stats_mon_tb_top;
  localparam int SW = 22;
  localparam int RW = 24;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] sample = '0;
  logic          valid = 1'b0, povf = 1'b0, novf = 1'b0;
  logic          dmax = 1'b0, trk = 1'b0, ld = 1'b0, snap = 1'b0, clr = 1'b0;
  logic [RW-1:0] ld_data = '0;
  logic [RW-1:0] level, level_buf;
  logic [CW-1:0] count, count_buf;

  always #2.5 clk = ~clk;

  sample_stats_mon #(.SAMPLE_W(SW), .REG_W(RW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .valid_i(valid),
    .pos_ovf_i(povf), .neg_ovf_i(novf), .dir_max_i(dmax), .track_i(trk),
    .thr_load_i(ld), .thr_data_i(ld_data), .snap_i(snap), .clr_i(clr),
    .level_o(level), .count_o(count), .level_buf_o(level_buf), .count_buf_o(count_buf)
  );

  typedef struct {
    logic [RW-1:0] lv;
    logic [CW-1:0] ct;
    logic [RW-1:0] lb;
    logic [CW-1:0] cb;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  logic [RW-1:0] m_lv = '0, m_lb = '0;
  logic [CW-1:0] m_ct = '0, m_cb = '0;

  task automatic chk(string tag, string what, logic [RW-1:0] act, logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle, advance the reference model, push expected result
  task automatic step(string tag, logic v, logic [SW-1:0] s, logic po, logic no,
                      logic dm, logic tr, logic l, logic [RW-1:0] ldv,
                      logic sn, logic cl);
    exp_t e;
    logic signed [SW-1:0] thr, smp;
    logic up, dn, hit, upd;
    @(negedge clk);
    valid = v; sample = s; povf = po; novf = no; dmax = dm; trk = tr;
    ld = l; ld_data = ldv; snap = sn; clr = cl;
    thr = m_lv[SW-1:0];
    smp = s;
    up  = po ? 1'b1 : (no ? 1'b0 : (smp > thr));
    dn  = po ? 1'b0 : (no ? 1'b1 : (smp < thr));
    hit = dm ? up : dn;
    upd = v && tr && hit && !po && !no;
    if (sn) begin m_lb = m_lv; m_cb = m_ct; end
    if (cl) m_ct = '0;
    else if (v && (tr ? upd : hit) && m_ct != {CW{1'b1}}) m_ct = m_ct + 1'b1;
    if (l) m_lv = ldv;
    else if (upd) m_lv = {{(RW-SW){s[SW-1]}}, s};
    @(posedge clk);
    #1;
    e.lv = m_lv; e.ct = m_ct; e.lb = m_lb; e.cb = m_cb; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic smp_step(string tag, logic [SW-1:0] s, logic dm, logic tr);
    step(tag, 1'b1, s, 1'b0, 1'b0, dm, tr, 1'b0, '0, 1'b0, 1'b0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "level", level, e.lv);
      chk(e.tag, "count", {{(RW-CW){1'b0}}, count}, {{(RW-CW){1'b0}}, e.ct});
      chk(e.tag, "level_buf", level_buf, e.lb);
      chk(e.tag, "count_buf", {{(RW-CW){1'b0}}, count_buf}, {{(RW-CW){1'b0}}, e.cb});
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "level", level, '0);
    chk("R1", "count", {{(RW-CW){1'b0}}, count}, '0);
    chk("R1", "level_buf", level_buf, '0);
    chk("R1", "count_buf", {{(RW-CW){1'b0}}, count_buf}, '0);
    rst_n = 1'b1;
    step("R1", 1'b0, '0, 0, 0, 0, 0, 0, '0, 0, 0);

    // R12 load threshold 100, overshoot counting
    step("R12", 1'b0, '0, 0, 0, 1, 0, 1, 24'd100, 0, 0);
    // R2 invalid samples ignored
    step("R2", 1'b0, 22'd500, 0, 0, 1, 0, 0, '0, 0, 0);
    step("R2", 1'b0, 22'd500, 0, 0, 1, 1, 0, '0, 0, 0);
    // R3 overshoot
    smp_step("R3", 22'd100, 1, 0);
    smp_step("R3", 22'd101, 1, 0);
    smp_step("R3", -22'sd5, 1, 0);
    smp_step("R3", 22'd200, 1, 0);
    // R11 clear beats an increment
    step("R11", 1'b1, 22'd300, 0, 0, 1, 0, 0, '0, 0, 1);
    // R4 undershoot
    smp_step("R4", 22'd99, 0, 0);
    smp_step("R4", 22'd100, 0, 0);
    smp_step("R4", -22'sd2000000, 0, 0);
    smp_step("R4", 22'd150, 0, 0);
    // R5 overflow flags in counting functions
    step("R5", 1'b1, 22'd0, 0, 1, 0, 0, 0, '0, 0, 0);
    step("R5", 1'b1, -22'sd5, 1, 0, 0, 0, 0, '0, 0, 0);
    step("R5", 1'b1, 22'd0, 1, 0, 1, 0, 0, '0, 0, 0);
    step("R5", 1'b1, 22'd900, 0, 1, 1, 0, 0, '0, 0, 0);
    step("R5", 1'b1, -22'sd900, 1, 1, 1, 0, 0, '0, 0, 0);
    // R12 load wins over tracking update
    step("R12", 1'b1, 22'd5000, 0, 0, 1, 1, 1, 24'd7, 0, 0);
    // R6 max tracking from most negative
    step("R6", 1'b0, '0, 0, 0, 1, 1, 1, 24'hE00000, 0, 1);
    smp_step("R6", -22'sd10, 1, 1);
    smp_step("R6", -22'sd20, 1, 1);
    smp_step("R6", 22'd50, 1, 1);
    smp_step("R6", 22'd50, 1, 1);
    // R8 flagged samples never tracked
    step("R8", 1'b1, 22'd1000, 1, 0, 1, 1, 0, '0, 0, 0);
    step("R8", 1'b1, -22'sd1000, 0, 1, 0, 1, 0, '0, 0, 0);
    // R7 min tracking
    smp_step("R7", 22'd40, 0, 1);
    smp_step("R7", 22'd60, 0, 1);
    smp_step("R7", -22'sd1000, 0, 1);
    smp_step("R7", -22'sd1000, 0, 1);
    // R10 snapshot takes pre-edge values during an update
    step("R10", 1'b1, -22'sd3000, 0, 0, 0, 1, 0, '0, 1, 0);
    smp_step("R10", -22'sd4000, 0, 1);
    step("R10", 1'b0, '0, 0, 0, 0, 1, 0, '0, 1, 0);
    // R9 saturation of the narrow counter
    step("R9", 1'b0, '0, 0, 0, 1, 0, 1, 24'hE00000, 0, 1);
    for (int i = 0; i < 70; i++) smp_step("R9", 22'd0, 1, 0);
    step("R9", 1'b0, '0, 0, 0, 1, 0, 0, '0, 1, 0);
    step("R11", 1'b1, 22'd0, 0, 0, 1, 0, 0, '0, 0, 1);
    step("R2", 1'b0, '0, 0, 0, 1, 0, 0, '0, 0, 0);

    wait (q.size() == 0);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule